// File: doc/BRIEF.md
# Serial register access bridge

This block lets a host on a serial line read and write an internal register bank. It contains an 8N1 UART receiver and transmitter that share one oversampling baud tick. It also contains a frame engine. The engine takes the escaping out of incoming bytes, parses read and write requests, and runs one access at a time on a simple request/acknowledge register bus with a 16-bit address and 32-bit data. It then frames and escapes a reply and sends it back on the same link.

A request starts with the frame marker 0x7E. Next comes a command byte: 0x01 reads, 0x02 writes. Then come the address bytes, most significant first. A write request adds the data bytes, also most significant first. Inside a frame, any byte equal to 0x7E or 0x7D is sent as 0x7D followed by the value XOR 0x20. A read is answered with the marker, the command and the data. A write is answered with the marker, the command and 0x00.

Top module: `uart_reg_bridge`

## Requirements
- R1: The transmitter sends each byte as one low start bit, eight data bits least significant first and one high stop bit, each bit lasting 16 baud ticks. The line sits high when nothing is being sent.
- R2: The receiver detects the falling edge of a start bit, checks the start bit at mid-bit, and then samples each later bit at mid-bit using 16 ticks per bit. A byte whose stop bit samples low is dropped, and reception resumes at the next falling edge.
- R3: A read request (0x7E, 0x01, address high, address low) drives one bus cycle with reg_we_o low and reg_addr_o set to that address.
- R4: A write request (0x7E, 0x02, address high, address low, four data bytes most significant first) drives one bus cycle with reg_we_o high and that address and data.
- R5: Once reg_req_o rises, it stays high, and address, data and write enable stay stable, until the cycle in which reg_ack_i is sampled high.
- R6: After a read is acknowledged, the reply is 0x7E, 0x01 and then reg_rdata_i as captured at acknowledge, most significant byte first. No reply byte starts while a bus cycle is pending.
- R7: After a write is acknowledged, the reply is 0x7E, 0x02, 0x00.
- R8: In a request, 0x7D followed by a byte b stands for the value b XOR 0x20. The escaped value goes into the command, address or data field.
- R9: In a reply, every byte after the leading 0x7E that equals 0x7E or 0x7D is sent as 0x7D followed by the value XOR 0x20.
- R10: A 0x7E received in the middle of a request throws away the partial request and starts a new one.
- R11: A request whose command is neither 0x01 nor 0x02 causes no bus cycle and no reply.
- R12: While reset is held, and after it is released, tx_o is high and reg_req_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Serial data from host |
| tx_o | output | 1 | Serial data to host |
| reg_req_o | output | 1 | Register bus request, held until acknowledged |
| reg_we_o | output | 1 | High for a write access |
| reg_addr_o | output | 16 | Register address |
| reg_wdata_o | output | 32 | Write data |
| reg_ack_i | input | 1 | Register bus acknowledge |
| reg_rdata_i | input | 32 | Read data, valid with acknowledge |

## Verification
The bench builds the bridge with CLK_HZ=3200000 and BAUD=100000. This gives a tick every 2 clocks and 32 clocks per bit, instead of 27 clocks per tick by default. That makes whole multi-byte requests and replies short enough to run many of them: escaped fields, aborted frames, unknown commands and bad stop bits. The address and data widths stay at 16 and 32 bits, so the byte counts and byte order checked are the real ones.

// File: rtl/urb_pkg.sv
package urb_pkg;
  localparam logic [7:0] SOF    = 8'h7E;
  localparam logic [7:0] ESC    = 8'h7D;
  localparam logic [7:0] XMASK  = 8'h20;
  localparam logic [7:0] CMD_RD = 8'h01;
  localparam logic [7:0] CMD_WR = 8'h02;
  localparam logic [7:0] ACKB   = 8'h00;

  typedef enum logic [2:0] {F_IDLE, F_CMD, F_ADDR, F_DATA, F_BUS, F_RESP} fstate_t;
  typedef enum logic [1:0] {R_IDLE, R_START, R_DATA, R_STOP} rstate_t;
endpackage

// File: rtl/urb_baud.sv
module urb_baud #(
  parameter int DIV = 27
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt <= '0;
    else if (cnt == LAST)  cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  assign tick_o = (cnt == LAST);
endmodule

// File: rtl/urb_rx.sv
module urb_rx
  import urb_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       rx_i,
  output logic       valid_o,
  output logic [7:0] data_o
);
  logic    s1, s2, prev;
  rstate_t st;
  logic [3:0] tcnt;
  logic [2:0] bcnt;
  logic [7:0] sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1 <= 1'b1; s2 <= 1'b1; prev <= 1'b1;
      st <= R_IDLE; tcnt <= '0; bcnt <= '0; sh <= '0;
      valid_o <= 1'b0; data_o <= '0;
    end else begin
      s1 <= rx_i; s2 <= s1; prev <= s2;
      valid_o <= 1'b0;
      case (st)
        R_IDLE: if (prev && !s2) begin st <= R_START; tcnt <= '0; end
        R_START: if (tick_i) begin
          if (tcnt == 4'd7) begin
            tcnt <= '0; bcnt <= '0;
            st <= s2 ? R_IDLE : R_DATA;  // glitch rejection at mid start bit
          end else tcnt <= tcnt + 1'b1;
        end
        R_DATA: if (tick_i) begin
          if (tcnt == 4'd15) begin
            tcnt <= '0;
            sh   <= {s2, sh[7:1]};
            if (bcnt == 3'd7) st <= R_STOP;
            bcnt <= bcnt + 1'b1;
          end else tcnt <= tcnt + 1'b1;
        end
        R_STOP: if (tick_i) begin
          if (tcnt == 4'd15) begin
            tcnt    <= '0;
            valid_o <= s2;  // low stop bit: drop byte
            data_o  <= sh;
            st      <= R_IDLE;
          end else tcnt <= tcnt + 1'b1;
        end
        default: st <= R_IDLE;
      endcase
    end
  end

  // R2
  rx_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
endmodule

// File: rtl/urb_tx.sv
module urb_tx (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       valid_i,
  input  logic [7:0] data_i,
  output logic       ready_o,
  output logic       tx_o
);
  logic       busy;
  logic [9:0] sh;
  logic [3:0] tcnt;
  logic [3:0] bcnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy <= 1'b0; sh <= '1; tcnt <= '0; bcnt <= '0;
    end else if (!busy) begin
      if (valid_i) begin
        sh <= {1'b1, data_i, 1'b0};
        busy <= 1'b1; tcnt <= '0; bcnt <= '0;
      end
    end else if (tick_i) begin
      if (tcnt == 4'd15) begin
        tcnt <= '0;
        sh   <= {1'b1, sh[9:1]};
        if (bcnt == 4'd9) busy <= 1'b0;
        else              bcnt <= bcnt + 1'b1;
      end else tcnt <= tcnt + 1'b1;
    end
  end

  assign ready_o = !busy;
  assign tx_o    = busy ? sh[0] : 1'b1;

  // R1
  tx_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && ready_o |=> !tx_o);
endmodule

// File: rtl/urb_frame.sv
module urb_frame
  import urb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_data_i,
  input  logic              tx_ready_i,
  output logic              tx_valid_o,
  output logic [7:0]        tx_data_o,
  output logic              reg_req_o,
  output logic              reg_we_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  input  logic              reg_ack_i,
  input  logic [DATA_W-1:0] reg_rdata_i
);
  localparam int AB = ADDR_W / 8;
  localparam int DB = DATA_W / 8;
  localparam int CW = $clog2((AB > DB ? AB : DB) + 1);
  localparam int IW = $clog2(DB + 2);
  localparam logic [CW-1:0] A_LAST = CW'(AB - 1);
  localparam logic [CW-1:0] D_LAST = CW'(DB - 1);
  localparam logic [IW-1:0] RD_LAST = IW'(DB + 1);
  localparam logic [IW-1:0] WR_LAST = IW'(2);

  fstate_t           st;
  logic              esc;
  logic [CW-1:0]     cnt;
  logic [7:0]        cmd;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] data;
  logic [IW-1:0]     ridx;
  logic              r_esc;

  logic [7:0] val, cur;
  logic       need_esc, last;

  assign val = esc ? (rx_data_i ^ XMASK) : rx_data_i;

  always_comb begin
    if (ridx == '0)                cur = SOF;
    else if (ridx == IW'(1))       cur = cmd;
    else if (cmd == CMD_RD)        cur = data[DATA_W-1 -: 8];
    else                           cur = ACKB;
    need_esc  = (ridx != '0) && (cur == SOF || cur == ESC);
    last      = (ridx == ((cmd == CMD_RD) ? RD_LAST : WR_LAST));
    tx_data_o = r_esc ? (cur ^ XMASK) : (need_esc ? ESC : cur);
  end

  assign tx_valid_o  = (st == F_RESP);
  assign reg_req_o   = (st == F_BUS);
  assign reg_we_o    = (cmd == CMD_WR);
  assign reg_addr_o  = addr;
  assign reg_wdata_o = data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= F_IDLE; esc <= 1'b0; cnt <= '0; cmd <= '0;
      addr <= '0; data <= '0; ridx <= '0; r_esc <= 1'b0;
    end else begin
      case (st)
        F_BUS: if (reg_ack_i) begin
          data <= reg_rdata_i; st <= F_RESP; ridx <= '0; r_esc <= 1'b0;
        end
        F_RESP: if (tx_ready_i) begin
          if (need_esc && !r_esc) r_esc <= 1'b1;
          else begin
            r_esc <= 1'b0;
            if (ridx >= IW'(2)) data <= data << 8;
            if (last) st <= F_IDLE;
            else      ridx <= ridx + 1'b1;
          end
        end
        default: if (rx_valid_i) begin
          if (rx_data_i == SOF) begin  // always restarts a frame
            st <= F_CMD; esc <= 1'b0; cnt <= '0;
          end else if (rx_data_i == ESC) begin
            esc <= 1'b1;
          end else begin
            esc <= 1'b0;
            case (st)
              F_CMD: begin
                cnt <= '0;
                if (val == CMD_RD || val == CMD_WR) begin cmd <= val; st <= F_ADDR; end
                else st <= F_IDLE;
              end
              F_ADDR: begin
                addr <= {addr[ADDR_W-9:0], val};
                cnt  <= cnt + 1'b1;
                if (cnt == A_LAST) begin
                  cnt <= '0;
                  st  <= (cmd == CMD_WR) ? F_DATA : F_BUS;
                end
              end
              F_DATA: begin
                data <= {data[DATA_W-9:0], val};
                cnt  <= cnt + 1'b1;
                if (cnt == D_LAST) st <= F_BUS;
              end
              default: ;
            endcase
          end
        end
      endcase
    end
  end

  // R5
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_o && !reg_ack_i |=> reg_req_o && $stable(reg_addr_o)
                                && $stable(reg_wdata_o) && $stable(reg_we_o));
  // R6
  tx_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_o |-> !tx_valid_o);
  // R11
  cmd_known_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_o |-> (cmd == CMD_RD || cmd == CMD_WR));
endmodule

// File: rtl/uart_reg_bridge.sv
module uart_reg_bridge #(
  parameter int CLK_HZ = 50_000_000,
  parameter int BAUD   = 115_200,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  output logic              tx_o,
  output logic              reg_req_o,
  output logic              reg_we_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  input  logic              reg_ack_i,
  input  logic [DATA_W-1:0] reg_rdata_i
);
  localparam int DIV_RAW = CLK_HZ / (BAUD * 16);
  localparam int DIV     = (DIV_RAW < 1) ? 1 : DIV_RAW;

  logic       tick, rx_valid, tx_valid, tx_ready;
  logic [7:0] rx_data, tx_data;

  urb_baud #(.DIV(DIV)) u_baud (.clk_i, .rst_ni, .tick_o(tick));

  urb_rx u_rx (
    .clk_i, .rst_ni, .tick_i(tick), .rx_i,
    .valid_o(rx_valid), .data_o(rx_data)
  );

  urb_tx u_tx (
    .clk_i, .rst_ni, .tick_i(tick), .valid_i(tx_valid),
    .data_i(tx_data), .ready_o(tx_ready), .tx_o
  );

  urb_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk_i, .rst_ni,
    .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .tx_ready_i(tx_ready), .tx_valid_o(tx_valid), .tx_data_o(tx_data),
    .reg_req_o, .reg_we_o, .reg_addr_o, .reg_wdata_o,
    .reg_ack_i, .reg_rdata_i
  );
endmodule

// File: tb/uart_reg_bridge_tb.sv
module uart_reg_bridge_tb;
  localparam int CLK_HZ = 3_200_000;
  localparam int BAUD   = 100_000;
  localparam int BITC   = CLK_HZ / BAUD;

  logic        clk = 1'b0, rst_n = 1'b0, rx = 1'b1;
  logic        tx, req, we, ack = 1'b0;
  logic [15:0] addr;
  logic [31:0] wdata, rdata = '0;

  int n_chk = 0, n_bad = 0;

  typedef struct { bit we; logic [15:0] a; logic [31:0] d; } acc_t;
  logic [7:0]  rxq[$];
  acc_t        busq[$];
  logic [31:0] mem[logic [15:0]];

  always #10 clk = ~clk;

  uart_reg_bridge #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .tx_o(tx),
    .reg_req_o(req), .reg_we_o(we), .reg_addr_o(addr), .reg_wdata_o(wdata),
    .reg_ack_i(ack), .reg_rdata_i(rdata)
  );

  task automatic chk(bit ok, string r, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", r, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rd_val(logic [15:0] a);
    return mem.exists(a) ? mem[a] : {16'hA5A5, a};
  endfunction

  // register bank model and per-clock bus hold check (R5)
  initial begin
    int wcnt = 0;
    logic p_req = 0, p_ack = 0, p_we = 0;
    logic [15:0] p_a = '0;
    logic [31:0] p_d = '0;
    forever begin
      @(negedge clk);
      if (p_req && !p_ack)
        chk(req === 1'b1 && addr === p_a && wdata === p_d && we === p_we,
            "R5", "bus hold", {15'd0, req, addr}, {15'd1, p_req, p_a});
      p_req = req; p_a = addr; p_d = wdata; p_we = we;
      if (ack) ack = 1'b0;
      else if (req) begin
        wcnt++;
        if (wcnt == 3) begin
          busq.push_back('{we, addr, wdata});
          if (we) mem[addr] = wdata;
          rdata = rd_val(addr);
          ack = 1'b1; wcnt = 0;
        end
      end
      p_ack = ack;
    end
  end

  // serial monitor on tx (R1)
  initial begin
    logic [7:0] b;
    forever begin
      @(negedge clk);
      if (tx === 1'b0) begin
        repeat (BITC / 2) @(negedge clk);
        chk(tx === 1'b0, "R1", "start bit", {31'd0, tx}, 32'd0);
        for (int i = 0; i < 8; i++) begin
          repeat (BITC) @(negedge clk);
          b[i] = tx;
        end
        repeat (BITC) @(negedge clk);
        chk(tx === 1'b1, "R1", "stop bit", {31'd0, tx}, 32'd1);
        rxq.push_back(b);
      end
    end
  end

  task automatic send_byte(logic [7:0] b, bit stop = 1'b1);
    rx = 1'b0; repeat (BITC) @(negedge clk);
    for (int i = 0; i < 8; i++) begin rx = b[i]; repeat (BITC) @(negedge clk); end
    rx = stop; repeat (BITC) @(negedge clk);
    rx = 1'b1; repeat (BITC) @(negedge clk);
  endtask

  task automatic send_body(logic [7:0] b);
    if (b == 8'h7E || b == 8'h7D) begin send_byte(8'h7D); send_byte(b ^ 8'h20); end
    else send_byte(b);
  endtask

  task automatic send_req(logic [7:0] c, logic [15:0] a, logic [31:0] d);
    send_byte(8'h7E); send_body(c); send_body(a[15:8]); send_body(a[7:0]);
    if (c == 8'h02) for (int i = 3; i >= 0; i--) send_body(d[i*8 +: 8]);
  endtask

  function automatic void stuff(ref logic [7:0] q[$], input logic [7:0] b);
    if (b == 8'h7E || b == 8'h7D) begin q.push_back(8'h7D); q.push_back(b ^ 8'h20); end
    else q.push_back(b);
  endfunction

  task automatic expect_reply(logic [7:0] c, logic [31:0] d, string r);
    logic [7:0] e[$];
    int t = 0;
    e.push_back(8'h7E); stuff(e, c);
    if (c == 8'h01) for (int i = 3; i >= 0; i--) stuff(e, d[i*8 +: 8]);
    else stuff(e, 8'h00);
    while (rxq.size() < e.size() && t < 8000) begin @(negedge clk); t++; end
    repeat (400) @(negedge clk);
    chk(rxq.size() == e.size(), r, "reply length", rxq.size(), e.size());
    for (int i = 0; i < e.size() && i < rxq.size(); i++)
      chk(rxq[i] === e[i], r, $sformatf("reply byte %0d", i), {24'd0, rxq[i]}, {24'd0, e[i]});
    rxq.delete();
  endtask

  task automatic expect_bus(bit w, logic [15:0] a, logic [31:0] d, string r);
    chk(busq.size() == 1, r, "bus count", busq.size(), 1);
    if (busq.size() > 0) begin
      chk(busq[0].we == w, r, "bus we", {31'd0, busq[0].we}, {31'd0, w});
      chk(busq[0].a === a, r, "bus addr", {16'd0, busq[0].a}, {16'd0, a});
      if (w) chk(busq[0].d === d, r, "bus wdata", busq[0].d, d);
    end
    busq.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=%h exp=%h", 0, 1);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 during reset
    chk(tx === 1'b1 && req === 1'b0, "R12", "in reset", {30'd0, tx, req}, 32'h2);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk(tx === 1'b1 && req === 1'b0, "R12", "after reset", {30'd0, tx, req}, 32'h2);

    // R4 R7 plain write
    send_req(8'h02, 16'h1234, 32'hDEADBEEF);
    expect_reply(8'h02, 32'h0, "R7");
    expect_bus(1'b1, 16'h1234, 32'hDEADBEEF, "R4");

    // R3 R6 read back
    send_req(8'h01, 16'h1234, 32'h0);
    expect_reply(8'h01, 32'hDEADBEEF, "R6");
    expect_bus(1'b0, 16'h1234, 32'h0, "R3");

    // R8 escaped address and data in request
    send_req(8'h02, 16'h7D7E, 32'h7E7D2000);
    expect_reply(8'h02, 32'h0, "R8");
    expect_bus(1'b1, 16'h7D7E, 32'h7E7D2000, "R8");

    // R9 escaped reply data
    send_req(8'h01, 16'h7D7E, 32'h0);
    expect_reply(8'h01, 32'h7E7D2000, "R9");
    expect_bus(1'b0, 16'h7D7E, 32'h0, "R9");

    // R10 frame marker aborts partial write
    send_byte(8'h7E); send_byte(8'h02); send_byte(8'h12);
    send_req(8'h01, 16'h0005, 32'h0);
    expect_reply(8'h01, 32'hA5A50005, "R10");
    expect_bus(1'b0, 16'h0005, 32'h0, "R10");

    // R11 unknown command ignored
    send_req(8'h03, 16'h0001, 32'h0);
    repeat (3000) @(negedge clk);
    chk(rxq.size() == 0, "R11", "no reply", rxq.size(), 0);
    chk(busq.size() == 0, "R11", "no bus", busq.size(), 0);

    // R2 byte with low stop bit dropped
    send_byte(8'h7E); send_byte(8'h01);
    send_byte(8'h00, 1'b0);
    send_byte(8'h00); send_byte(8'h10);
    expect_reply(8'h01, 32'hA5A50010, "R2");
    expect_bus(1'b0, 16'h0010, 32'h0, "R2");

    chk(tx === 1'b1 && req === 1'b0, "R1", "idle line", {30'd0, tx, req}, 32'h2);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule